// File: doc/BRIEF.md
# Indexed Effective-Address Generator

This unit turns one indexed-mode postbyte into a 16-bit effective address for an accumulator-based CPU with two index registers (X, Y), a stack pointer and a program counter. When `start` is seen while the unit is idle, it captures the postbyte and the current register and accumulator values. It then pulls zero, one or two offset bytes from the instruction byte stream, reads a two-byte pointer from memory for the indirect forms, and reports the address with a one-cycle `done` pulse.

The postbyte selects one of five families: a short signed constant offset held in the postbyte itself, a 9-bit or 16-bit constant offset completed by stream bytes, a 16-bit offset used to locate a pointer, an accumulator offset, and an accumulator-D offset used to locate a pointer. A sixth family steps X, Y or SP by a signed amount before or after use. For that family the unit also hands back the stepped register value on a writeback port, so the register file can keep it. All sums wrap within the 64 KB space. The PC value at the input is used exactly as given.

Top module: `idx_ea_unit`

## Requirements
- R1: The base register code is postbyte[7:6], or postbyte[4:3] when postbyte[7:5] = 111. Code 0 = X, 1 = Y, 2 = SP, 3 = PC.
- R2: A postbyte with bit 5 clear gives base + sign-extended postbyte[4:0] (range -16..+15), with no stream bytes and `ext_count` = 0.
- R3: A postbyte 111rr00s takes one stream byte as the low offset bits, with s as the sign. The result is base + that 9-bit value, and `ext_count` = 1.
- R4: A postbyte 111rr010 takes two stream bytes, the high byte first, and gives base + that 16-bit offset, with `ext_count` = 2.
- R5: A postbyte 111rr011 takes two stream bytes (high first) and forms ptr = base + offset. It then reads memory at ptr (high byte) and at ptr+1 (low byte). The 16-bit word read is the result.
- R6: A postbyte rr1pnnnn with rr other than 11 steps the base by nnnn: 0000..0111 mean +1..+8 and 1000..1111 mean -8..-1. With p = 0 the result is the stepped value; with p = 1 it is the unstepped base.
- R7: Only the stepping family raises `wb_en`, together with `done`. `wb_sel` is then the base code (never 3) and `wb_val` is the stepped value. Every other family leaves `wb_en` low.
- R8: A postbyte 111rr1aa with aa = 00 adds A, and with aa = 01 adds B, each zero-extended. With aa = 10 it adds the 16-bit D.
- R9: A postbyte 111rr111 forms ptr = base + D and reads the high byte at ptr and the low byte at ptr+1. The result is that word, and `ext_count` = 0.
- R10: All address sums, including ptr+1, wrap modulo 2^16.
- R11: A stream byte is taken only in a cycle with `ext_valid` and `ext_ready` both high. A memory byte is taken only with `rd_valid` and `rd_ready` both high. While `rd_ready` is low, `rd_valid` and `rd_addr` hold.
- R12: Each accepted operation gives exactly one `done` cycle with `ea` valid. Forms that need no transfers complete in the cycle after `start`. `start` is ignored while `busy`, and a `start` in the `done` cycle is accepted. The PC base is used unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation (taken only when idle) |
| postbyte | input | 8 | Indexed-mode postbyte |
| reg_x | input | 16 | X index register |
| reg_y | input | 16 | Y index register |
| reg_sp | input | 16 | Stack pointer |
| reg_pc | input | 16 | Program counter value to use as base |
| acc_a | input | 8 | Accumulator A |
| acc_b | input | 8 | Accumulator B |
| acc_d | input | 16 | Double accumulator D |
| ext_valid | input | 1 | Stream byte available |
| ext_data | input | 8 | Stream byte |
| ext_ready | output | 1 | Unit will take a stream byte |
| rd_valid | output | 1 | Memory byte read request |
| rd_addr | output | 16 | Memory byte address |
| rd_ready | input | 1 | Memory returns `rd_data` this cycle |
| rd_data | input | 8 | Memory byte |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| ea | output | 16 | Effective address |
| ext_count | output | 2 | Stream bytes consumed by the last operation |
| wb_en | output | 1 | Write back the stepped index register |
| wb_sel | output | 2 | Register code to write back |
| wb_val | output | 16 | Value to write back |

## Verification
The completion of one operation can fall in the same cycle as the acceptance of the next one. The `done` pulse, with its address and any register writeback, is on the outputs in the very cycle in which a new `start` is sampled. The bench provokes this by holding `start` high for two cycles: first with a pre-increment postbyte, then with a short-offset postbyte. It expects the first address and writeback in the first `done` cycle, and the second address, with no writeback, in the following cycle. A separate case shows that a `start` raised while stream bytes are still outstanding leaves no trace: exactly one `done` follows.

// File: rtl/idx_ea_unit.sv
module idx_ea_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [7:0]  postbyte,
  input  logic [15:0] reg_x,
  input  logic [15:0] reg_y,
  input  logic [15:0] reg_sp,
  input  logic [15:0] reg_pc,
  input  logic [7:0]  acc_a,
  input  logic [7:0]  acc_b,
  input  logic [15:0] acc_d,
  input  logic        ext_valid,
  input  logic [7:0]  ext_data,
  output logic        ext_ready,
  output logic        rd_valid,
  output logic [15:0] rd_addr,
  input  logic        rd_ready,
  input  logic [7:0]  rd_data,
  output logic        busy,
  output logic        done,
  output logic [15:0] ea,
  output logic [1:0]  ext_count,
  output logic        wb_en,
  output logic [1:0]  wb_sel,
  output logic [15:0] wb_val
);
  typedef enum logic [2:0] {S_IDLE, S_EXT_HI, S_EXT_LO, S_RD_HI, S_RD_LO} state_t;
  state_t st;

  logic        ind_q;
  logic [7:0]  off_hi_q, ptr_hi_q;
  logic [15:0] base_q, ptr_q;
  logic [15:0] base_in, acc_off;

  wire       grp7 = (postbyte[7:5] == 3'b111);
  wire [1:0] rsel = grp7 ? postbyte[4:3] : postbyte[7:6];

  always_comb begin
    case (rsel)
      2'd0:    base_in = reg_x;
      2'd1:    base_in = reg_y;
      2'd2:    base_in = reg_sp;
      default: base_in = reg_pc;
    endcase
  end

  always_comb begin
    case (postbyte[1:0])
      2'b00:   acc_off = {8'd0, acc_a};
      2'b01:   acc_off = {8'd0, acc_b};
      default: acc_off = acc_d;
    endcase
  end

  wire [15:0] off5    = {{11{postbyte[4]}}, postbyte[4:0]};
  wire [15:0] step    = postbyte[3] ? {12'hFFF, postbyte[3:0]} : ({12'd0, postbyte[3:0]} + 16'd1);
  wire [15:0] stepped = base_in + step;
  wire [15:0] acc_sum = base_in + acc_off;
  wire [15:0] ext_sum = base_q + {off_hi_q, ext_data};
  wire        ext_take = ext_valid && ext_ready;
  wire        rd_take  = rd_valid && rd_ready;

  assign busy      = (st != S_IDLE);
  assign ext_ready = (st == S_EXT_HI) || (st == S_EXT_LO);
  assign rd_valid  = (st == S_RD_HI) || (st == S_RD_LO);
  assign rd_addr   = (st == S_RD_LO) ? ptr_q + 16'd1 : ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      ind_q     <= 1'b0;
      off_hi_q  <= '0;
      ptr_hi_q  <= '0;
      base_q    <= '0;
      ptr_q     <= '0;
      done      <= 1'b0;
      ea        <= '0;
      ext_count <= '0;
      wb_en     <= 1'b0;
      wb_sel    <= '0;
      wb_val    <= '0;
    end else begin
      done  <= 1'b0;
      wb_en <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          base_q    <= base_in;
          ind_q     <= postbyte[1] & postbyte[0];
          ext_count <= 2'd0;
          wb_sel    <= rsel;
          if (!postbyte[5]) begin
            ea   <= base_in + off5;
            done <= 1'b1;
          end else if (!grp7) begin
            ea     <= postbyte[4] ? base_in : stepped;
            wb_val <= stepped;
            wb_en  <= 1'b1;
            done   <= 1'b1;
          end else if (postbyte[2]) begin
            if (postbyte[1:0] == 2'b11) begin
              ptr_q <= acc_sum;
              st    <= S_RD_HI;
            end else begin
              ea   <= acc_sum;
              done <= 1'b1;
            end
          end else if (!postbyte[1]) begin
            off_hi_q <= {8{postbyte[0]}};
            st       <= S_EXT_LO;
          end else begin
            st <= S_EXT_HI;
          end
        end
        S_EXT_HI: if (ext_take) begin
          off_hi_q  <= ext_data;
          ext_count <= 2'd1;
          st        <= S_EXT_LO;
        end
        S_EXT_LO: if (ext_take) begin
          ext_count <= ext_count + 2'd1;
          if (ind_q) begin
            ptr_q <= ext_sum;
            st    <= S_RD_HI;
          end else begin
            ea   <= ext_sum;
            done <= 1'b1;
            st   <= S_IDLE;
          end
        end
        S_RD_HI: if (rd_take) begin
          ptr_hi_q <= rd_data;
          st       <= S_RD_LO;
        end
        S_RD_LO: if (rd_take) begin
          ea   <= {ptr_hi_q, rd_data};
          done <= 1'b1;
          st   <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_done_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_start_ack_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy || done));

  p_wb_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (done && wb_sel != 2'b11));

  p_rd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));

  p_ptr_low_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(rd_valid && rd_ready)) |-> (ea[7:0] == $past(rd_data)));

endmodule

// File: tb/idx_ea_unit_test.sv
`timescale 1ns/1ps
module idx_ea_unit_test;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [7:0] postbyte = '0, acc_a = 8'hF0, acc_b = 8'h05, ext_data = '0, rd_data;
  logic [15:0] reg_x = 16'h1000, reg_y = 16'h2000, reg_sp = 16'h3000, reg_pc = 16'h4000, acc_d = 16'h0123;
  logic ext_valid = 1'b0, rd_ready = 1'b1;
  logic ext_ready, rd_valid, busy, done, wb_en;
  logic [15:0] rd_addr, ea, wb_val;
  logic [1:0] ext_count, wb_sel;
  int checks = 0, errors = 0, ndone = 0, nrd = 0;
  logic [15:0] rd_log [0:7];
  bit finished = 0;

  always #2.5 clk = ~clk;

  idx_ea_unit uut (.clk(clk), .rst_n(rst_n), .start(start), .postbyte(postbyte),
    .reg_x(reg_x), .reg_y(reg_y), .reg_sp(reg_sp), .reg_pc(reg_pc),
    .acc_a(acc_a), .acc_b(acc_b), .acc_d(acc_d),
    .ext_valid(ext_valid), .ext_data(ext_data), .ext_ready(ext_ready),
    .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rd_ready), .rd_data(rd_data),
    .busy(busy), .done(done), .ea(ea), .ext_count(ext_count),
    .wb_en(wb_en), .wb_sel(wb_sel), .wb_val(wb_val));

  assign rd_data = rd_addr[7:0] + 8'h11;

  always @(posedge clk) begin
    if (done) ndone++;
    if (rd_valid && rd_ready) begin
      if (nrd < 8) rd_log[nrd] = rd_addr;
      nrd++;
    end
  end

  // {postbyte, ea, wb_en, wb_sel, wb_val}
  localparam logic [42:0] VEC [11] = '{
    {8'h00, 16'h1000, 1'b0, 2'd0, 16'h0000},
    {8'h4F, 16'h200F, 1'b0, 2'd0, 16'h0000},
    {8'h90, 16'h2FF0, 1'b0, 2'd0, 16'h0000},
    {8'hD1, 16'h3FF1, 1'b0, 2'd0, 16'h0000},
    {8'h23, 16'h1004, 1'b1, 2'd0, 16'h1004},
    {8'h3F, 16'h1000, 1'b1, 2'd0, 16'h0FFF},
    {8'hA7, 16'h3008, 1'b1, 2'd2, 16'h3008},
    {8'h78, 16'h2000, 1'b1, 2'd1, 16'h1FF8},
    {8'hEC, 16'h20F0, 1'b0, 2'd0, 16'h0000},
    {8'hFD, 16'h4005, 1'b0, 2'd0, 16'h0000},
    {8'hF6, 16'h3123, 1'b0, 2'd0, 16'h0000}
  };

  task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic push_ext(input logic [7:0] b);
    ext_valid = 1'b1;
    ext_data  = b;
    while (!ext_ready) @(negedge clk);
    @(negedge clk);
    ext_valid = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    for (int i = 0; i < 40 && !done; i++) @(negedge clk);
    chk(tag, "done seen", {15'd0, done}, 16'd1);
  endtask

  task automatic run_op(input logic [7:0] pb, input int nb, input logic [7:0] b0, input logic [7:0] b1,
                        input logic [15:0] exp_ea, input logic [1:0] exp_cnt, input string tag);
    postbyte = pb;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (nb > 0) push_ext(b0);
    if (nb > 1) push_ext(b1);
    wait_done(tag);
    chk(tag, "ea", ea, exp_ea);
    chk(tag, "ext_count", {14'd0, ext_count}, {14'd0, exp_cnt});
    chk(tag, "wb_en", {15'd0, wb_en}, 16'd0);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12", "reset done", {15'd0, done}, 16'd0);
    chk("R12", "reset busy", {15'd0, busy}, 16'd0);
    chk("R11", "reset ext_ready", {15'd0, ext_ready}, 16'd0);
    chk("R11", "reset rd_valid", {15'd0, rd_valid}, 16'd0);
    chk("R7", "reset wb_en", {15'd0, wb_en}, 16'd0);

    // R1 R2 R6 R7 R8 R12: single-cycle forms from the table
    for (int i = 0; i < 11; i++) begin
      logic [42:0] v;
      string tag;
      v = VEC[i];
      tag = !v[37] ? "R2" : (v[42:40] != 3'b111) ? "R6" : "R8";
      postbyte = v[42:35];
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(tag, "done", {15'd0, done}, 16'd1);
      chk(tag, "ea", ea, v[34:19]);
      chk(tag, "ext_count", {14'd0, ext_count}, 16'd0);
      chk("R7", "wb_en", {15'd0, wb_en}, {15'd0, v[18]});
      if (v[18]) begin
        chk("R7", "wb_sel", {14'd0, wb_sel}, {14'd0, v[17:16]});
        chk("R7", "wb_val", wb_val, v[15:0]);
      end
      @(negedge clk);
      chk("R12", "done one cycle", {15'd0, done}, 16'd0);
    end

    run_op(8'hE1, 1, 8'h00, 8'h00, 16'h0F00, 2'd1, "R3");
    run_op(8'hE8, 1, 8'hFF, 8'h00, 16'h20FF, 2'd1, "R3");
    run_op(8'hF2, 2, 8'h12, 8'h34, 16'h4234, 2'd2, "R4");
    run_op(8'hFA, 2, 8'hF0, 8'h00, 16'h3000, 2'd2, "R10");

    // R4 R11: gaps in the byte stream
    postbyte = 8'hF2; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11", "busy in gap", {15'd0, busy}, 16'd1);
    chk("R11", "no done in gap", {15'd0, done}, 16'd0);
    push_ext(8'h00);
    repeat (2) @(negedge clk);
    chk("R11", "no done after one byte", {15'd0, done}, 16'd0);
    push_ext(8'h05);
    wait_done("R4");
    chk("R4", "ea after gaps", ea, 16'h3005);

    // R5 R11: indirect with memory stall
    @(negedge clk);
    rd_ready = 1'b0; nrd = 0;
    postbyte = 8'hE3; start = 1'b1;
    @(negedge clk); start = 1'b0;
    push_ext(8'h00); push_ext(8'h10);
    chk("R11", "rd_valid stalled", {15'd0, rd_valid}, 16'd1);
    chk("R5", "ptr address", rd_addr, 16'h1010);
    repeat (3) @(negedge clk);
    chk("R11", "rd_addr held", rd_addr, 16'h1010);
    chk("R11", "no read taken", nrd[15:0], 16'd0);
    rd_ready = 1'b1;
    wait_done("R5");
    chk("R5", "indirect ea", ea, 16'h2122);
    chk("R5", "ext_count", {14'd0, ext_count}, 16'd2);
    chk("R5", "reads", nrd[15:0], 16'd2);
    chk("R5", "second read addr", rd_log[1], 16'h1011);
    @(negedge clk);

    run_op(8'hEF, 0, 8'h00, 8'h00, 16'h3435, 2'd0, "R9");

    // R10: pointer high byte at FFFF, low byte wraps to 0000
    reg_pc = 16'hFEDC; nrd = 0;
    run_op(8'hFF, 0, 8'h00, 8'h00, 16'h1011, 2'd0, "R10");
    chk("R10", "first read addr", rd_log[0], 16'hFFFF);
    chk("R10", "wrapped read addr", rd_log[1], 16'h0000);
    reg_pc = 16'h4000;

    // R12: start while busy is ignored
    ndone = 0;
    postbyte = 8'hF2; start = 1'b1;
    @(negedge clk);
    postbyte = 8'h00;
    @(negedge clk); start = 1'b0;
    push_ext(8'h00); push_ext(8'h05);
    wait_done("R12");
    chk("R12", "ignored start ea", ea, 16'h3005);
    repeat (4) @(negedge clk);
    chk("R12", "single done", ndone[15:0], 16'd1);

    // R12 R7: completion and next acceptance in one cycle
    postbyte = 8'h23; start = 1'b1;
    @(negedge clk);
    postbyte = 8'h4F;
    chk("R7", "first done", {15'd0, done}, 16'd1);
    chk("R7", "first ea", ea, 16'h1004);
    chk("R7", "first wb", {15'd0, wb_en}, 16'd1);
    chk("R7", "first wb_val", wb_val, 16'h1004);
    @(negedge clk); start = 1'b0;
    chk("R12", "second done", {15'd0, done}, 16'd1);
    chk("R12", "second ea", ea, 16'h200F);
    chk("R7", "second wb", {15'd0, wb_en}, 16'd0);
    @(negedge clk);
    chk("R12", "quiet after pair", {15'd0, done}, 16'd0);

    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL R12 watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule